// File: doc/BRIEF.md
# Interrupt Aggregation and Throttling Controller

This block gathers single-cycle event pulses from three classes of data-movement sources and turns them into a small set of interrupt request pulses. There are twelve transmit-done sources, twelve receive-done sources and twelve receive-low sources. Each event latches into a pending bit. Software enables a source with its mask bit. A 4-bit steering field picks which of the sixteen vectors the source drives.

Every vector has its own rate limiter. After the vector sends a request, the limiter reloads from a programmable interval and counts down on an external 256 ns tick. A new request on that vector waits until the count reaches zero. Software accesses the block through a flat register port with one-cycle read latency. Pending words clear when they are read, and both the pending and mask words have write-only bit-set and bit-clear aliases. An optional auto-clear mode drops the pending bits of a source once its request has been sent.

Top module: `irq_aggr`

Register word addresses: 0x00/0x01 pending, 0x02/0x03 pending-clear, 0x04/0x05 pending-set, 0x06/0x07 enable, 0x08/0x09 enable-clear, 0x0A/0x0B enable-set, 0x0C control (bit 0 = auto-clear), 0x10–0x14 steering, 0x20–0x2F vector throttle.

## Requirements
- R1: After reset, all pending, enable, steering, control and throttle state is zero, irq_o is low and every register reads zero.
- R2: Source numbering is transmit i = i, receive i = 12+i, receive-low i = 24+i. Source s has pending bit s%32 of pending word s/32, so word 0 holds transmit at bits 0–11, receive at 12–23 and receive-low 0–7 at 24–31, and word 1 bits 0–3 hold receive-low 8–11. A one-cycle event pulse sets that bit.
- R3: Read data appears in the cycle after rd_en_i and is zero whenever rd_en_i was low. Reading a pending word returns its bits and clears them. Write-only and unmapped addresses read zero.
- R4: Writing a 1 to a pending-clear or pending-set alias clears or sets the matching bit. Writing 0 to an alias leaves the bit unchanged.
- R5: The enable words are read-write with the same bit layout as the pending words, and only implemented bits read back. The enable-clear and enable-set aliases act bitwise. An enable bit of 1 lets its source request.
- R6: Source s has a 4-bit steering field at bit (4s)%32 of steering word 4s/32. A request is raised only on the vector named by that field.
- R7: A vector's request goes high one cycle after an enabled pending source steered to it is set. The request is a one-cycle pulse and fires once per rise of the vector's request condition. The vector re-arms only after that condition has dropped.
- R8: A throttle word holds the interval in bits 15:0 and a read-only live counter in bits 31:16. Firing loads the counter from the interval. Each tick_i decrements a non-zero counter. A vector does not fire while its counter is non-zero, and an interval of zero adds no delay.
- R9: When control bit 0 is set, the pending bits that caused a request are cleared in the same cycle the request pulse is issued.
- R10: When a hardware event and a software clear (alias write or read-clear) hit the same bit in the same cycle, the bit stays set.
- R11: A masked source stays pending without requesting. Enabling it later raises its vector's request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_done_i | input | 12 | Transmit-done event pulses |
| rx_done_i | input | 12 | Receive-done event pulses |
| rx_low_i | input | 12 | Receive-low event pulses |
| tick_i | input | 1 | 256 ns timebase tick, one cycle wide |
| addr_i | input | 6 | Register word address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Read data, one cycle after rd_en_i |
| irq_o | output | 16 | Per-vector interrupt request pulses |

## Verification
The bench places receive-low source 10 and source 35 so that an off-by-one in the word split would show up as a bit in the wrong pending word or the wrong steering field. It drives an event in the same cycle as an alias clear and as a read-clear; a design that lets the clear win would lose the event and read back zero. It lets a second event arrive while a vector's counter is still running and checks that the request is held until the last tick rather than issued at once or dropped. It also checks that a still-pending source does not re-fire without re-arming, and that a source enabled late fires; a design built on raw edges or levels would fail one of these two checks.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW = 32;
  localparam int AW = 6;

  localparam int A_ST    = 'h00;
  localparam int A_STC   = 'h02;
  localparam int A_STS   = 'h04;
  localparam int A_MK    = 'h06;
  localparam int A_MKC   = 'h08;
  localparam int A_MKS   = 'h0A;
  localparam int A_CTRL  = 'h0C;
  localparam int A_MAP   = 'h10;
  localparam int A_THR   = 'h20;

  function automatic int words_for(input int bits);
    return (bits + DW - 1) / DW;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 36
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] st_set_i,
  input  logic [N_SRC-1:0] st_clr_i,
  input  logic [N_SRC-1:0] mk_ld_en_i,
  input  logic [N_SRC-1:0] mk_ld_val_i,
  input  logic [N_SRC-1:0] mk_set_i,
  input  logic [N_SRC-1:0] mk_clr_i,
  output logic [N_SRC-1:0] stat_o,
  output logic [N_SRC-1:0] mask_o
);
  logic [N_SRC-1:0] stat_q, mask_q;

  // hardware events applied last so they are never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= ((stat_q & ~st_clr_i) | st_set_i) | evt_i;
      mask_q <= (((mask_q & ~mk_ld_en_i) | (mk_ld_val_i & mk_ld_en_i)) & ~mk_clr_i) | mk_set_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R10

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_clr_i & ~evt_i & ~st_set_i) != '0) |=>
      ((stat_q & $past(st_clr_i & ~evt_i & ~st_set_i)) == '0)); // R4
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int N_SRC     = 36,
  parameter int N_VEC     = 16,
  parameter int VEC_W     = 4,
  parameter int MAP_WORDS = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MAP_WORDS-1:0]      map_we_i,
  input  logic [irq_pkg::DW-1:0]    wdata_i,
  input  logic [N_SRC-1:0]          stat_i,
  input  logic [N_SRC-1:0]          mask_i,
  input  logic [N_VEC-1:0]          fire_i,
  output logic [N_SRC*VEC_W-1:0]    map_flat_o,
  output logic [N_VEC-1:0]          req_o,
  output logic [N_SRC-1:0]          sent_o
);
  localparam int DW = irq_pkg::DW;

  logic [VEC_W-1:0] map_q [N_SRC];
  logic [N_SRC-1:0] act;

  assign act = stat_i & mask_i;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    localparam int WRD = (s * VEC_W) / DW;
    localparam int OFF = (s * VEC_W) % DW;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            map_q[s] <= '0;
      else if (map_we_i[WRD]) map_q[s] <= wdata_i[OFF +: VEC_W];
    end
    assign map_flat_o[s*VEC_W +: VEC_W] = map_q[s];
    assign sent_o[s] = act[s] & fire_i[map_q[s]];
  end

  always_comb begin
    req_o = '0;
    for (int v = 0; v < N_VEC; v++) begin
      for (int s = 0; s < N_SRC; s++) begin
        if (act[s] && (map_q[s] == VEC_W'(v))) req_o[v] = 1'b1;
      end
    end
  end

  AST_SENT_IS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_o & ~(stat_i & mask_i)) == '0); // R9
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             intv_we_i,
  input  logic [CNT_W-1:0] intv_i,
  output logic             fire_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] intv_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] intv_q, cnt_q;
  logic             armed_q, irq_q, fire;

  assign fire = req_i && armed_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      intv_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= fire;
      if (intv_we_i) intv_q <= intv_i;
      if (fire)         armed_q <= 1'b0;
      else if (!req_i)  armed_q <= 1'b1;
      if (fire)                       cnt_q <= intv_q;
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire_o = fire;
  assign irq_o  = irq_q;
  assign intv_o = intv_q;
  assign cnt_o  = cnt_q;

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R7

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (cnt_q == $past(intv_q))); // R8

  AST_HOLD_WHILE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> !irq_q); // R8

  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == '0) && !fire) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
  import irq_pkg::*;
#(
  parameter int N_PER_CLASS = 12,
  parameter int N_VEC       = 16,
  parameter int CNT_W       = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PER_CLASS-1:0] tx_done_i,
  input  logic [N_PER_CLASS-1:0] rx_done_i,
  input  logic [N_PER_CLASS-1:0] rx_low_i,
  input  logic                   tick_i,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_en_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   rd_en_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [N_VEC-1:0]       irq_o
);
  localparam int N_SRC     = 3 * N_PER_CLASS;
  localparam int VEC_W     = $clog2(N_VEC);
  localparam int ST_WORDS  = words_for(N_SRC);
  localparam int MAP_WORDS = words_for(N_SRC * VEC_W);

  logic [N_SRC-1:0] evt, stat, mask, sent;
  logic [N_SRC-1:0] st_set, st_clr, mk_ld_en, mk_ld_val, mk_set, mk_clr;
  logic [N_VEC-1:0] req, fire;
  logic [N_SRC*VEC_W-1:0] map_flat;
  logic [MAP_WORDS-1:0] map_we;
  logic [CNT_W-1:0] intv [N_VEC];
  logic [CNT_W-1:0] cnt  [N_VEC];
  logic [ST_WORDS*DW-1:0]  stat_w, mask_w;
  logic [MAP_WORDS*DW-1:0] map_w;
  logic auto_clr_q;
  logic [DW-1:0] rd_q, rd_d;

  assign evt = {rx_low_i, rx_done_i, tx_done_i};

  always_comb begin
    for (int s = 0; s < N_SRC; s++) begin
      st_set[s]    = wr_en_i && addr_i == AW'(A_STS + s / DW) && wr_data_i[s % DW];
      st_clr[s]    = (wr_en_i && addr_i == AW'(A_STC + s / DW) && wr_data_i[s % DW])
                   || (rd_en_i && addr_i == AW'(A_ST + s / DW))
                   || (auto_clr_q && sent[s]);
      mk_ld_en[s]  = wr_en_i && addr_i == AW'(A_MK + s / DW);
      mk_ld_val[s] = wr_data_i[s % DW];
      mk_set[s]    = wr_en_i && addr_i == AW'(A_MKS + s / DW) && wr_data_i[s % DW];
      mk_clr[s]    = wr_en_i && addr_i == AW'(A_MKC + s / DW) && wr_data_i[s % DW];
    end
    for (int w = 0; w < MAP_WORDS; w++)
      map_we[w] = wr_en_i && addr_i == AW'(A_MAP + w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 auto_clr_q <= 1'b0;
    else if (wr_en_i && addr_i == AW'(A_CTRL)) auto_clr_q <= wr_data_i[0];
  end

  irq_src_bank #(.N_SRC(N_SRC)) u_src_bank (
    .clk_i, .rst_ni,
    .evt_i      (evt),
    .st_set_i   (st_set),
    .st_clr_i   (st_clr),
    .mk_ld_en_i (mk_ld_en),
    .mk_ld_val_i(mk_ld_val),
    .mk_set_i   (mk_set),
    .mk_clr_i   (mk_clr),
    .stat_o     (stat),
    .mask_o     (mask)
  );

  irq_route #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W), .MAP_WORDS(MAP_WORDS)) u_route (
    .clk_i, .rst_ni,
    .map_we_i  (map_we),
    .wdata_i   (wr_data_i),
    .stat_i    (stat),
    .mask_i    (mask),
    .fire_i    (fire),
    .map_flat_o(map_flat),
    .req_o     (req),
    .sent_o    (sent)
  );

  for (genvar v = 0; v < N_VEC; v++) begin : g_vec
    irq_throttle #(.CNT_W(CNT_W)) u_thr (
      .clk_i, .rst_ni, .tick_i,
      .req_i    (req[v]),
      .intv_we_i(wr_en_i && addr_i == AW'(A_THR + v)),
      .intv_i   (wr_data_i[CNT_W-1:0]),
      .fire_o   (fire[v]),
      .irq_o    (irq_o[v]),
      .intv_o   (intv[v]),
      .cnt_o    (cnt[v])
    );
  end

  assign stat_w = (ST_WORDS*DW)'(stat);
  assign mask_w = (ST_WORDS*DW)'(mask);
  assign map_w  = (MAP_WORDS*DW)'(map_flat);

  always_comb begin
    rd_d = '0;
    for (int w = 0; w < ST_WORDS; w++) begin
      if (addr_i == AW'(A_ST + w)) rd_d = stat_w[w*DW +: DW];
      if (addr_i == AW'(A_MK + w)) rd_d = mask_w[w*DW +: DW];
    end
    for (int w = 0; w < MAP_WORDS; w++)
      if (addr_i == AW'(A_MAP + w)) rd_d = map_w[w*DW +: DW];
    for (int v = 0; v < N_VEC; v++)
      if (addr_i == AW'(A_THR + v)) rd_d = DW'({cnt[v], intv[v]});
    if (addr_i == AW'(A_CTRL)) rd_d = DW'(auto_clr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_en_i ? rd_d : '0;
  end

  assign rd_data_o = rd_q;

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0)); // R3

  AST_IRQ_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(stat & mask) != '0)); // R11
endmodule

// File: tb/irq_aggr_bench.sv
module irq_aggr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] tx = '0, rx = '0, lo = '0;
  logic        tick = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] irq;
  int n_chk = 0, n_fail = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  irq_aggr u_irq_aggr (
    .clk_i(clk), .rst_ni(rst_n), .tx_done_i(tx), .rx_done_i(rx), .rx_low_i(lo),
    .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
    .rd_en_i(rd_en), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int cls, input int idx);
    @(negedge clk);
    if (cls == 0) tx[idx] = 1'b1; else if (cls == 1) rx[idx] = 1'b1; else lo[idx] = 1'b1;
    @(negedge clk); tx = '0; rx = '0; lo = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 irq", 32'(irq), 0);
    rd(6'h00, r); chk("R1 pending0", r, 0);
    rd(6'h07, r); chk("R1 enable1", r, 0);
    rd(6'h12, r); chk("R1 steer2", r, 0);
    rd(6'h2F, r); chk("R1 throttle15", r, 0);
    rd(6'h0C, r); chk("R1 control", r, 0);
  endtask

  task automatic t_layout();
    pulse(0, 3); pulse(1, 5); pulse(2, 2); pulse(2, 10);
    chk("R11 masked no irq", 32'(irq), 0);
    rd(6'h00, r); chk("R2 word0 layout", r, 32'h0402_0008);
    rd(6'h01, r); chk("R2 word1 layout", r, 32'h0000_0004);
    rd(6'h00, r); chk("R3 read clears", r, 0);
    rd(6'h0F, r); chk("R3 unmapped", r, 0);
    rd(6'h04, r); chk("R3 write-only", r, 0);
  endtask

  task automatic t_setclr();
    wr(6'h04, 32'h0000_00F0);
    wr(6'h02, 32'h0000_0030);
    rd(6'h00, r); chk("R4 set then clear", r, 32'h0000_00C0);
    wr(6'h05, 32'h0000_0005);
    wr(6'h03, 32'h0000_0000);
    wr(6'h05, 32'h0000_0000);
    rd(6'h01, r); chk("R4 zero write no effect", r, 32'h0000_0005);
  endtask

  task automatic t_mask();
    wr(6'h06, 32'hFFFF_FFFF);
    rd(6'h06, r); chk("R5 enable0 rw", r, 32'hFFFF_FFFF);
    wr(6'h07, 32'hFFFF_FFFF);
    rd(6'h07, r); chk("R5 enable1 implemented bits", r, 32'h0000_000F);
    wr(6'h08, 32'h0000_000F);
    rd(6'h06, r); chk("R5 enable clear", r, 32'hFFFF_FFF0);
    wr(6'h0A, 32'h0000_0001);
    rd(6'h06, r); chk("R5 enable set", r, 32'hFFFF_FFF1);
    wr(6'h08, 32'hFFFF_FFFF);
    wr(6'h09, 32'hFFFF_FFFF);
    rd(6'h06, r); chk("R5 enable cleared", r, 0);
  endtask

  task automatic t_route();
    wr(6'h10, 32'h0000_0090);
    rd(6'h10, r); chk("R6 steer0 readback", r, 32'h0000_0090);
    wr(6'h0A, 32'h0000_0002);
    pulse(0, 1);
    chk("R7 no irq yet", 32'(irq), 0);
    @(negedge clk); chk("R6 R7 vector 9", 32'(irq), 32'h0200);
    @(negedge clk); chk("R7 single pulse", 32'(irq), 0);
    pulse(0, 1);
    @(negedge clk); @(negedge clk);
    chk("R7 no refire while pending", 32'(irq), 0);
    rd(6'h00, r); chk("R7 pending before rearm", r, 32'h0000_0002);
    pulse(0, 1);
    @(negedge clk); chk("R7 rearmed fires", 32'(irq), 32'h0200);
    rd(6'h00, r);
    wr(6'h14, 32'hFFFF_F000);
    rd(6'h14, r); chk("R6 steer4 fields", r, 32'h0000_F000);
    wr(6'h0B, 32'h0000_0008);
    pulse(2, 11);
    @(negedge clk); chk("R6 source 35 to vector 15", 32'(irq), 32'h8000);
    rd(6'h01, r); chk("R2 source 35 pending", r, 32'h0000_0008);
    wr(6'h09, 32'hFFFF_FFFF);
  endtask

  task automatic t_throttle();
    wr(6'h0C, 32'h1);
    wr(6'h29, 32'h3);
    pulse(0, 1);
    @(negedge clk); chk("R8 first fire", 32'(irq), 32'h0200);
    rd(6'h29, r); chk("R8 counter loaded", r, 32'h0003_0003);
    rd(6'h00, r); chk("R9 auto-clear", r, 0);
    pulse(0, 1);
    @(negedge clk); chk("R8 held", 32'(irq), 0);
    @(negedge clk); chk("R8 still held", 32'(irq), 0);
    ticks(2);
    rd(6'h29, r); chk("R8 counter after 2 ticks", r, 32'h0001_0003);
    ticks(1);
    chk("R8 held until zero", 32'(irq), 0);
    @(negedge clk); chk("R8 fires at zero", 32'(irq), 32'h0200);
    rd(6'h00, r); chk("R9 cleared after held fire", r, 0);
    wr(6'h0C, 32'h0);
    wr(6'h29, 32'h0);
    ticks(3);
    rd(6'h29, r); chk("R8 drained", r, 0);
    wr(6'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    @(negedge clk); tx[4] = 1'b1; wr_en = 1'b1; addr = 6'h02; wdata = 32'h10;
    @(negedge clk); tx = '0; wr_en = 1'b0;
    rd(6'h00, r); chk("R10 event beats alias clear", r, 32'h0000_0010);
    wr(6'h04, 32'h0000_0020);
    @(negedge clk); tx[5] = 1'b1; rd_en = 1'b1; addr = 6'h00;
    @(negedge clk); tx = '0; rd_en = 1'b0;
    chk("R3 read returns pending", rdata, 32'h0000_0020);
    rd(6'h00, r); chk("R10 event beats read clear", r, 32'h0000_0020);
    rd(6'h00, r); chk("R3 cleared", r, 0);
  endtask

  task automatic t_late_mask();
    pulse(1, 0);
    @(negedge clk); @(negedge clk);
    chk("R11 masked held", 32'(irq), 0);
    wr(6'h0A, 32'h0000_1000);
    @(negedge clk); chk("R11 late enable fires vector 0", 32'(irq), 32'h0001);
    rd(6'h00, r); chk("R11 still pending", r, 32'h0000_1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_setclr();
    rd(6'h00, r); rd(6'h01, r);
    t_mask();
    t_route();
    t_throttle();
    t_race();
    t_late_mask();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule